// File: doc/BRIEF.md
# Memory Training Sequencer

This block runs a write/read-back calibration pass for the data I/O timing of a low-power DDR memory. When it is triggered, it asks the command path for ownership and waits for a grant. It then sweeps a delay tap across its full range. At each tap it writes a fixed set of sixteen pattern words into a reserved window and reads them back. A tap counts as passing only if every read word matches. After the last tap, the block picks the centre of the longest contiguous run of passing taps, drives that tap out and raises pass. If no tap passed, it lowers pass.

The end of any initialization sequence triggers a pass. This includes the re-initialization that follows exit from deep power-down. A build-time parameter can also make the end of each auto-refresh burst trigger a pass. A trigger that arrives while a pass is running is remembered, and exactly one further pass runs once the current pass has finished.

Top module: `mem_train_seq`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, req_o and mem_cmd_valid_o are low and tap_o is 0.
- R2: A one-cycle pulse on init_done_i while idle makes busy_o and req_o high from the next cycle.
- R3: No memory command is issued while grant_i is low; the block keeps busy_o and req_o high and waits.
- R4: For each tap the block issues 16 writes and then 16 reads, all to bank 0, row 0, columns 0 to 15 in ascending order. Word k is 0xA5A5 for even k below 8, 0x5A5A for odd k below 8, and 1<<k for k from 8 to 15.
- R5: Taps are tried in order 0 to 7. tap_o carries the tap under test during its accesses. A tap passes only if all 16 read words equal the written pattern.
- R6: If any tap passes, pass_o is 1 and tap_o is the lower middle of the longest run of passing taps. When two runs have equal length, the run starting at the lower tap is used.
- R7: If no tap passes, pass_o is 0 and tap_o is 0.
- R8: done_o is high for exactly one cycle and busy_o is high during it. pass_o and tap_o are valid while done_o is high and are held until the next pass starts. busy_o is low the cycle after done_o when no trigger is pending.
- R9: With TRAIN_ON_REFRESH=1, a pulse on refresh_done_i starts a pass. With TRAIN_ON_REFRESH=0, the same pulse leaves busy_o and req_o low.
- R10: Triggers that arrive during a pass cause exactly one additional pass, which starts two cycles after done_o.
- R11: A later init_done_i pulse (re-initialization, for example after deep power-down) runs a new pass and replaces the previous pass_o and tap_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Pulse at the end of memory initialization |
| refresh_done_i | input | 1 | Pulse at the end of an auto-refresh burst |
| grant_i | input | 1 | Command path granted to this block |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data word |
| req_o | output | 1 | Request for the command path |
| mem_cmd_valid_o | output | 1 | Memory command valid this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_bank_o | output | BANK_W | Bank address |
| mem_row_o | output | ROW_W | Row address |
| mem_col_o | output | COL_W | Column address |
| mem_wdata_o | output | DATA_W | Write data word |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| pass_o | output | 1 | At least one tap passed |
| tap_o | output | TAP_W | Tap under test, then the selected tap |

## Verification
The bench targets run selection with pass masks that have tied runs, runs at either end of the tap range, all-pass and all-fail cases. A selector that picks the later of two tied runs, rounds the centre upward or leaves a stale tap after total failure would report the wrong tap. Triggers sent while grant is withheld, or while a pass is already running, expose a design that issues commands early, drops the pending trigger or runs once per trigger instead of once in total. A second instance built without refresh triggering shows whether a refresh pulse leaks through. A memory model corrupts reads at chosen taps and checks the order, address and pattern of every access.

// File: rtl/trn_pkg.sv
package trn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WR, ST_RD, ST_RWAIT, ST_NEXT, ST_SEL, ST_FIN
  } trn_state_e;
endpackage

// File: rtl/trn_trigger.sv
module trn_trigger #(
  parameter int TRAIN_ON_REFRESH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic refresh_done_i,
  input  logic idle_i,
  output logic start_o
);
  localparam logic OnRefresh = (TRAIN_ON_REFRESH != 0);

  logic trig;
  logic pending_q;

  assign trig    = init_done_i | (refresh_done_i & OnRefresh);
  assign start_o = idle_i & (trig | pending_q);

  // any number of triggers while busy collapse into one extra pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pending_q <= 1'b0;
    else if (start_o) pending_q <= 1'b0;
    else if (trig)    pending_q <= 1'b1;
  end

  p_pending_runs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && idle_i) |-> start_o);
endmodule

// File: rtl/trn_window.sv
module trn_window #(
  parameter int TAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic             ok_i,
  output logic             any_pass_o,
  output logic [TAP_W-1:0] best_tap_o
);
  localparam int NumTaps = 1 << TAP_W;

  logic [NumTaps-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (wr_i)  mask_q[tap_i] <= ok_i;
  end

  // longest run, first one wins ties; centre = end - len/2 (lower middle)
  always_comb begin
    int cur, best, best_end;
    cur = 0;
    best = 0;
    best_end = 0;
    for (int t = 0; t < NumTaps; t++) begin
      if (mask_q[t]) cur = cur + 1;
      else           cur = 0;
      if (cur > best) begin
        best     = cur;
        best_end = t;
      end
    end
    best_tap_o = TAP_W'(best_end - best / 2);
  end

  assign any_pass_o = |mask_q;

  p_sel_is_passing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pass_o |-> mask_q[best_tap_o]);
endmodule

// File: rtl/trn_ctrl.sv
module trn_ctrl
  import trn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAP_W  = 3,
  parameter int WORDS  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     grant_i,
  input  logic                     rd_valid_i,
  input  logic [DATA_W-1:0]        rd_data_i,
  input  logic                     any_pass_i,
  input  logic [TAP_W-1:0]         best_tap_i,
  output logic                     req_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     cmd_valid_o,
  output logic                     cmd_we_o,
  output logic [$clog2(WORDS)-1:0] col_o,
  output logic [DATA_W-1:0]        wdata_o,
  output logic [TAP_W-1:0]         tap_o,
  output logic                     pass_o,
  output logic                     win_clr_o,
  output logic                     win_wr_o,
  output logic                     win_ok_o
);
  localparam int IdxW = $clog2(WORDS);
  localparam logic [IdxW-1:0]  LastIdx = IdxW'(WORDS - 1);
  localparam logic [TAP_W-1:0] LastTap = '1;

  trn_state_e      state_q;
  logic [IdxW-1:0] idx_q;
  logic [TAP_W-1:0] tap_q;
  logic            fail_q;
  logic            pass_q;

  function automatic logic [DATA_W-1:0] pat(input logic [IdxW-1:0] k);
    logic [DATA_W-1:0] v;
    if (int'(k) < 8) v = {(DATA_W/8){k[0] ? 8'h5A : 8'hA5}};
    else             v = DATA_W'(1) << k;
    return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tap_q   <= '0;
      fail_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_REQ;
          idx_q   <= '0;
          tap_q   <= '0;
          fail_q  <= 1'b0;
          pass_q  <= 1'b0;
        end
        ST_REQ: if (grant_i) state_q <= ST_WR;
        ST_WR: if (grant_i) begin
          if (idx_q == LastIdx) begin
            idx_q   <= '0;
            state_q <= ST_RD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RD: if (grant_i) state_q <= ST_RWAIT;
        ST_RWAIT: if (rd_valid_i) begin
          if (rd_data_i != pat(idx_q)) fail_q <= 1'b1;
          if (idx_q == LastIdx) begin
            idx_q   <= '0;
            state_q <= ST_NEXT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        ST_NEXT: begin
          if (tap_q == LastTap) begin
            state_q <= ST_SEL;
          end else begin
            tap_q   <= tap_q + 1'b1;
            fail_q  <= 1'b0;
            state_q <= ST_WR;
          end
        end
        ST_SEL: begin
          pass_q  <= any_pass_i;
          tap_q   <= any_pass_i ? best_tap_i : '0;
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign req_o       = busy_o && (state_q != ST_SEL) && (state_q != ST_FIN);
  assign cmd_valid_o = grant_i && ((state_q == ST_WR) || (state_q == ST_RD));
  assign cmd_we_o    = (state_q == ST_WR);
  assign col_o       = idx_q;
  assign wdata_o     = pat(idx_q);
  assign tap_o       = tap_q;
  assign pass_o      = pass_q;
  assign win_clr_o   = (state_q == ST_IDLE) && start_i;
  assign win_wr_o    = (state_q == ST_NEXT);
  assign win_ok_o    = !fail_q;

  p_cmd_needs_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (grant_i && req_o));
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!req_o && !cmd_valid_o));
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_fail_tap_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (tap_o == '0));
  p_tap_steps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && $past(state_q) == ST_NEXT) |-> (tap_q == TAP_W'($past(tap_q) + 1'b1)));
endmodule

// File: rtl/mem_train_seq.sv
module mem_train_seq #(
  parameter int TRAIN_ON_REFRESH = 1,
  parameter int DATA_W = 16,
  parameter int TAP_W  = 3,
  parameter int WORDS  = 16,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              refresh_done_i,
  input  logic              grant_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              req_o,
  output logic              mem_cmd_valid_o,
  output logic              mem_we_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [TAP_W-1:0]  tap_o
);
  localparam int IdxW = $clog2(WORDS);

  logic            start;
  logic            any_pass;
  logic [TAP_W-1:0] best_tap;
  logic            win_clr, win_wr, win_ok;
  logic [IdxW-1:0] col;

  trn_trigger #(.TRAIN_ON_REFRESH(TRAIN_ON_REFRESH)) u_trig (
    .clk_i, .rst_ni, .init_done_i, .refresh_done_i,
    .idle_i(!busy_o), .start_o(start)
  );

  trn_window #(.TAP_W(TAP_W)) u_win (
    .clk_i, .rst_ni, .clr_i(win_clr), .wr_i(win_wr), .tap_i(tap_o),
    .ok_i(win_ok), .any_pass_o(any_pass), .best_tap_o(best_tap)
  );

  trn_ctrl #(.DATA_W(DATA_W), .TAP_W(TAP_W), .WORDS(WORDS)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .grant_i, .rd_valid_i, .rd_data_i,
    .any_pass_i(any_pass), .best_tap_i(best_tap),
    .req_o, .busy_o, .done_o, .cmd_valid_o(mem_cmd_valid_o), .cmd_we_o(mem_we_o),
    .col_o(col), .wdata_o(mem_wdata_o), .tap_o, .pass_o,
    .win_clr_o(win_clr), .win_wr_o(win_wr), .win_ok_o(win_ok)
  );

  // reserved window: bank 0, row 0, low columns
  assign mem_bank_o = '0;
  assign mem_row_o  = '0;
  assign mem_col_o  = COL_W'(col);

  p_in_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_valid_o |-> (mem_bank_o == '0 && mem_row_o == '0 && int'(mem_col_o) < WORDS));
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_i && !busy_o) |=> (busy_o && req_o));
endmodule

// File: tb/tb_mem_train_seq.sv
module tb_mem_train_seq;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic init_done = 0, refresh_done = 0, gnt_en = 1, grant = 0;
  logic rd_valid;
  logic [15:0] rd_data;
  logic req, cmd_valid, we, busy, done, pass;
  logic [1:0] bank;
  logic [13:0] row;
  logic [9:0] col;
  logic [15:0] wdata;
  logic [2:0] tap;
  logic [7:0] good_mask = 8'hFF;

  mem_train_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .refresh_done_i(refresh_done),
    .grant_i(grant), .rd_valid_i(rd_valid), .rd_data_i(rd_data), .req_o(req),
    .mem_cmd_valid_o(cmd_valid), .mem_we_o(we), .mem_bank_o(bank), .mem_row_o(row),
    .mem_col_o(col), .mem_wdata_o(wdata), .busy_o(busy), .done_o(done),
    .pass_o(pass), .tap_o(tap)
  );

  logic n_req, n_cv, n_we, n_busy, n_done, n_pass;
  logic [1:0] n_bank;
  logic [13:0] n_row;
  logic [9:0] n_col;
  logic [15:0] n_wd;
  logic [2:0] n_tap;
  mem_train_seq #(.TRAIN_ON_REFRESH(0)) dut_ni (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(1'b0), .refresh_done_i(refresh_done),
    .grant_i(1'b1), .rd_valid_i(1'b0), .rd_data_i(16'h0), .req_o(n_req),
    .mem_cmd_valid_o(n_cv), .mem_we_o(n_we), .mem_bank_o(n_bank), .mem_row_o(n_row),
    .mem_col_o(n_col), .mem_wdata_o(n_wd), .busy_o(n_busy), .done_o(n_done),
    .pass_o(n_pass), .tap_o(n_tap)
  );

  function automatic logic [15:0] exp_pat(input int k);
    if (k < 8) return (k % 2 == 0) ? 16'hA5A5 : 16'h5A5A;
    return 16'h1 << k;
  endfunction

  // memory model and access monitor
  logic [15:0] mem [16];
  logic rv1, rv2;
  logic [15:0] rd1, rd2;
  int wr_cnt, rd_cnt, bad_addr, bad_pat, bad_order, bad_tap, no_gnt, done_cnt;
  assign rd_valid = rv2;
  assign rd_data  = rd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv1 <= 0; rv2 <= 0; rd1 <= '0; rd2 <= '0; grant <= 0;
      wr_cnt <= 0; rd_cnt <= 0; bad_addr <= 0; bad_pat <= 0;
      bad_order <= 0; bad_tap <= 0; no_gnt <= 0; done_cnt <= 0;
    end else begin
      grant <= req & gnt_en;
      rv1 <= 1'b0;
      rv2 <= rv1;
      rd2 <= rd1;
      if (done) done_cnt <= done_cnt + 1;
      if (cmd_valid) begin
        if (!grant) no_gnt <= no_gnt + 1;
        if (bank != 0 || row != 0 || col > 15) bad_addr <= bad_addr + 1;
        if (we) begin
          mem[col[3:0]] <= wdata;
          wr_cnt <= wr_cnt + 1;
          if (wdata != exp_pat(int'(col[3:0]))) bad_pat <= bad_pat + 1;
          if (int'(col) != wr_cnt % 16) bad_order <= bad_order + 1;
          if (int'(tap) != (wr_cnt / 16) % 8) bad_tap <= bad_tap + 1;
        end else begin
          rv1 <= 1'b1;
          rd1 <= mem[col[3:0]] ^ (good_mask[tap] ? 16'h0 : 16'h0001);
          rd_cnt <= rd_cnt + 1;
          if (int'(col) != rd_cnt % 16) bad_order <= bad_order + 1;
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input logic ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic pulse_init();
    @(negedge clk) init_done = 1;
    @(negedge clk) init_done = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk(0, tag, 0, 1);
  endtask

  // {mask, pass, tap}
  localparam logic [11:0] VEC [8] = '{
    {8'hFF, 1'b1, 3'd3}, {8'h00, 1'b0, 3'd0}, {8'h3C, 1'b1, 3'd3}, {8'h01, 1'b1, 3'd0},
    {8'h80, 1'b1, 3'd7}, {8'hE7, 1'b1, 3'd1}, {8'h73, 1'b1, 3'd5}, {8'h55, 1'b1, 3'd0}
  };

  initial begin
    int w0, r0, d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !pass && !req && !cmd_valid && tap == 0, "R1", int'(busy), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);

    // vector table: R4 R5 R6 R7
    foreach (VEC[i]) begin
      good_mask = VEC[i][11:4];
      w0 = wr_cnt; r0 = rd_cnt;
      pulse_init();
      wait_done("R8");
      chk(pass == VEC[i][3], "R6/R7 pass", int'(pass), int'(VEC[i][3]));
      chk(tap == VEC[i][2:0], "R6 tap R7", int'(tap), int'(VEC[i][2:0]));
      chk(busy, "R8 busy at done", int'(busy), 1);
      chk(wr_cnt - w0 == 128 && rd_cnt - r0 == 128, "R4 count", wr_cnt - w0, 128);
      @(negedge clk);
      chk(!busy && !done, "R8 busy falls", int'(busy), 0);
    end
    chk(bad_addr == 0 && bad_order == 0, "R4 addr/order", bad_addr + bad_order, 0);
    chk(bad_pat == 0, "R4 pattern", bad_pat, 0);
    chk(bad_tap == 0, "R5 tap sweep", bad_tap, 0);

    // R2 start timing, R3 grant hold-off
    gnt_en = 0; good_mask = 8'hFF; w0 = wr_cnt;
    @(negedge clk) init_done = 1;
    @(negedge clk) init_done = 0;
    chk(busy && req, "R2 start", int'(busy & req), 1);
    repeat (20) @(negedge clk);
    chk(wr_cnt == w0 && rd_cnt == r0 + 0 * 0 + (rd_cnt - r0), "R3 no access", wr_cnt - w0, 0);
    chk(busy && req && !cmd_valid, "R3 waiting", int'(busy & req), 1);
    gnt_en = 1;
    wait_done("R3");
    chk(pass && tap == 3, "R3 completes", int'(tap), 3);
    chk(no_gnt == 0, "R3 grant", no_gnt, 0);
    repeat (5) @(negedge clk);
    chk(pass && tap == 3 && !busy, "R8 held", int'(tap), 3);

    // R11 re-initialization replaces results
    good_mask = 8'h00;
    pulse_init();
    wait_done("R11");
    chk(!pass && tap == 0, "R11 rerun", int'(pass), 0);

    // R9 refresh trigger, both modes
    good_mask = 8'h3C;
    @(negedge clk) refresh_done = 1;
    @(negedge clk) refresh_done = 0;
    chk(busy && req, "R9 refresh starts", int'(busy), 1);
    chk(!n_busy && !n_req, "R9 init-only ignores", int'(n_busy), 0);
    wait_done("R9");
    chk(pass && tap == 3, "R9 result", int'(tap), 3);
    chk(!n_busy && !n_req, "R9 init-only still idle", int'(n_busy), 0);
    @(negedge clk);

    // R10 triggers during a pass give exactly one more pass
    d0 = done_cnt;
    good_mask = 8'hE7;
    pulse_init();
    repeat (50) @(negedge clk);
    @(negedge clk) refresh_done = 1;
    @(negedge clk) refresh_done = 0;
    repeat (30) @(negedge clk);
    @(negedge clk) init_done = 1;
    @(negedge clk) init_done = 0;
    wait_done("R10");
    chk(pass && tap == 1, "R10 first pass", int'(tap), 1);
    good_mask = 8'h80;
    @(negedge clk);
    chk(!busy, "R10 idle gap", int'(busy), 0);
    @(negedge clk);
    chk(busy, "R10 restarts", int'(busy), 1);
    wait_done("R10");
    chk(pass && tap == 7, "R10 second pass", int'(tap), 7);
    repeat (2000) @(negedge clk);
    chk(done_cnt - d0 == 2 && !busy, "R10 only one extra", done_cnt - d0, 2);

    finish_run();
  end
endmodule